// File: doc/BRIEF.md
# ALU Left Operand Source Selector

This block feeds the left operand of an 8-bit ALU inside a microcoded processor. Five sources can reach that operand: the X index register, a sign-fill view of X, a Y register held inside the block, and two external operands (an accumulator value and a temporary value). The control store has no spare output for a fifth select line. X and its sign-fill view therefore share one select strobe.

The block decides which of the two the shared strobe means by looking at the current microinstruction's destination. If that microinstruction loads the high byte of the program counter or the high byte of the address register, the sign-fill view drives the operand. Microcode uses this during address arithmetic, so that adding a signed X offset carries correctly into the high byte. For any other destination, X itself drives the operand.

The Y register loads from the data bus when its load strobe is high. The operand mux is combinational, so the output follows the select strobes in the same cycle.

Top module: `aluLeftSel`

## Requirements
- R1: When `rst` is high at a rising clock edge, the Y register becomes 0. Selecting Y afterwards yields 8'h00.
- R2: When `yLoad` is high and `rst` is low at a rising edge, the Y register takes the value of `dataBus`.
- R3: When `yLoad` and `rst` are both low at a rising edge, the Y register keeps its value.
- R4: With `xShareEn` high, `pcHiLoad` low and `arHiLoad` low, `aluLeft` equals `xVal`.
- R5: With `xShareEn` high and either `pcHiLoad` or `arHiLoad` high, `aluLeft` is 8'hFF when `xVal` bit 7 is 1, and 8'h00 when it is 0.
- R6: `ySel` drives the Y register onto `aluLeft`. `accSel` drives `accVal`, and `tmpSel` drives `tmpVal`.
- R7: With no select strobe high, `aluLeft` is 8'h00.
- R8: `pcHiLoad` and `arHiLoad` have no effect on `aluLeft` while `xShareEn` is low.
- R9: While Y is both selected and loaded in the same cycle, `aluLeft` shows the old Y value until the edge, and the new value after it.

At most one of the select strobes `xShareEn`, `ySel`, `accSel` and `tmpSel` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataBus | input | 8 | Load value for the Y register |
| yLoad | input | 1 | Y register load strobe |
| xVal | input | 8 | Current X register contents |
| accVal | input | 8 | Accumulator operand |
| tmpVal | input | 8 | Temporary operand |
| xShareEn | input | 1 | Shared select for X or its sign-fill view |
| ySel | input | 1 | Select Y |
| accSel | input | 1 | Select accumulator |
| tmpSel | input | 1 | Select temporary |
| pcHiLoad | input | 1 | Microinstruction loads the program counter high byte |
| arHiLoad | input | 1 | Microinstruction loads the address register high byte |
| aluLeft | output | 8 | Left ALU operand |

## Verification
Two functions can fall in the same cycle: writing the Y register and reading it onto the operand. The bench provokes this by holding `ySel` and `yLoad` high together with a new `dataBus` value. It expects the old Y before the edge and the loaded value after it. The shared-select decode is swept over every combination of `xShareEn`, `pcHiLoad` and `arHiLoad`, with X values on both sides of the sign boundary. Each result is compared against a model built from the requirements.

// File: rtl/aluLeftPkg.sv
package aluLeftPkg;
  // one output strobe per left-operand source
  typedef struct packed {
    logic xOe;
    logic x7Oe;
    logic yOe;
    logic accOe;
    logic tmpOe;
  } srcStrobes_t;
endpackage

// File: rtl/aluLeftCtrl.sv
module aluLeftCtrl
  import aluLeftPkg::*;
(
  input  logic        xShareEn,
  input  logic        ySel,
  input  logic        accSel,
  input  logic        tmpSel,
  input  logic        pcHiLoad,
  input  logic        arHiLoad,
  output srcStrobes_t strobes
);
  logic addrHiDest;

  // destination is an address high byte: use the sign-fill view of X
  assign addrHiDest = pcHiLoad | arHiLoad;

  always_comb begin
    strobes.xOe   = xShareEn & ~addrHiDest;
    strobes.x7Oe  = xShareEn &  addrHiDest;
    strobes.yOe   = ySel;
    strobes.accOe = accSel;
    strobes.tmpOe = tmpSel;
  end
endmodule

// File: rtl/aluLeftPath.sv
module aluLeftPath
  import aluLeftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              yLoad,
  input  logic [DATA_W-1:0] xVal,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] tmpVal,
  input  srcStrobes_t       strobes,
  output logic [DATA_W-1:0] aluLeft,
  output logic [DATA_W-1:0] yVal
);
  localparam int NUM_SRC  = 5;
  localparam int SIGN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] yReg;
  logic [DATA_W-1:0] srcVec    [NUM_SRC];
  logic [DATA_W-1:0] maskedVec [NUM_SRC];
  logic [NUM_SRC-1:0] enVec;

  always_ff @(posedge clk) begin
    if (rst)        yReg <= '0;
    else if (yLoad) yReg <= dataBus;
  end

  assign yVal = yReg;

  assign srcVec[0] = xVal;
  assign srcVec[1] = {DATA_W{xVal[SIGN_BIT]}};
  assign srcVec[2] = yReg;
  assign srcVec[3] = accVal;
  assign srcVec[4] = tmpVal;
  assign enVec = {strobes.tmpOe, strobes.accOe, strobes.yOe, strobes.x7Oe, strobes.xOe};

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gMask
      assign maskedVec[g] = enVec[g] ? srcVec[g] : '0;
    end
  endgenerate

  always_comb begin
    aluLeft = '0;
    for (int i = 0; i < NUM_SRC; i++) aluLeft = aluLeft | maskedVec[i];
  end
endmodule

// File: rtl/aluLeftSel.sv
module aluLeftSel
  import aluLeftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              yLoad,
  input  logic [DATA_W-1:0] xVal,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] tmpVal,
  input  logic              xShareEn,
  input  logic              ySel,
  input  logic              accSel,
  input  logic              tmpSel,
  input  logic              pcHiLoad,
  input  logic              arHiLoad,
  output logic [DATA_W-1:0] aluLeft
);
  srcStrobes_t       strobes;
  logic [DATA_W-1:0] yVal;

  aluLeftCtrl ctrl_i (
    .xShareEn(xShareEn), .ySel(ySel), .accSel(accSel), .tmpSel(tmpSel),
    .pcHiLoad(pcHiLoad), .arHiLoad(arHiLoad), .strobes(strobes)
  );

  aluLeftPath #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst(rst), .dataBus(dataBus), .yLoad(yLoad), .xVal(xVal),
    .accVal(accVal), .tmpVal(tmpVal), .strobes(strobes),
    .aluLeft(aluLeft), .yVal(yVal)
  );
endmodule

// File: rtl/aluLeftSel_chk.sv
module aluLeftSel_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dataBus,
  input logic              yLoad,
  input logic [DATA_W-1:0] xVal,
  input logic              xShareEn,
  input logic              ySel,
  input logic              accSel,
  input logic              tmpSel,
  input logic              pcHiLoad,
  input logic              arHiLoad,
  input logic [DATA_W-1:0] yVal,
  input logic [DATA_W-1:0] aluLeft
);
  logic otherSel;
  assign otherSel = ySel | accSel | tmpSel;

  assert_y_load_R2: assert property (@(posedge clk) disable iff (rst)
    yLoad |=> (yVal == $past(dataBus)));

  assert_y_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !yLoad |=> $stable(yVal));

  assert_x_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (xShareEn && !otherSel && !pcHiLoad && !arHiLoad) |-> (aluLeft == xVal));

  assert_sign_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (xShareEn && !otherSel && (pcHiLoad || arHiLoad)) |->
      (aluLeft == (xVal[DATA_W-1] ? {DATA_W{1'b1}} : {DATA_W{1'b0}})));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!xShareEn && !otherSel) |-> (aluLeft == '0));

  assert_y_read_R6: assert property (@(posedge clk) disable iff (rst)
    (ySel && !xShareEn && !accSel && !tmpSel) |-> (aluLeft == yVal));
endmodule

bind aluLeftSel aluLeftSel_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .dataBus(dataBus), .yLoad(yLoad), .xVal(xVal),
  .xShareEn(xShareEn), .ySel(ySel), .accSel(accSel), .tmpSel(tmpSel),
  .pcHiLoad(pcHiLoad), .arHiLoad(arHiLoad), .yVal(yVal), .aluLeft(aluLeft)
);

// File: tb/aluLeftSel_tb_top.sv
module aluLeftSel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dataBus = '0, xVal = '0, accVal = '0, tmpVal = '0;
  logic       yLoad = 1'b0, xShareEn = 1'b0, ySel = 1'b0, accSel = 1'b0, tmpSel = 1'b0;
  logic       pcHiLoad = 1'b0, arHiLoad = 1'b0;
  logic [7:0] aluLeft;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  aluLeftSel dut_i (
    .clk(clk), .rst(rst), .dataBus(dataBus), .yLoad(yLoad), .xVal(xVal),
    .accVal(accVal), .tmpVal(tmpVal), .xShareEn(xShareEn), .ySel(ySel),
    .accSel(accSel), .tmpSel(tmpSel), .pcHiLoad(pcHiLoad), .arHiLoad(arHiLoad),
    .aluLeft(aluLeft)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (aluLeft !== exp) begin
      fails++;
      $display("FAIL %s: aluLeft=%h expected=%h", req, aluLeft, exp);
    end
  endtask

  task automatic clearSel();
    xShareEn = 0; ySel = 0; accSel = 0; tmpSel = 0; pcHiLoad = 0; arHiLoad = 0; yLoad = 0;
  endtask

  // reference model for the shared select
  function automatic logic [7:0] sharedModel(input logic en, input logic pc,
                                             input logic ar, input logic [7:0] x);
    if (!en) return 8'h00;
    if (pc || ar) return x[7] ? 8'hFF : 8'h00;
    return x;
  endfunction

  task automatic loadY(input logic [7:0] v);
    @(negedge clk); clearSel(); dataBus = v; yLoad = 1;
    @(negedge clk); yLoad = 0;
  endtask

  task automatic testReset();
    @(negedge clk); clearSel(); ySel = 1; #2;
    check("R1", 8'h00);
  endtask

  task automatic testYLoadHold();
    loadY(8'hA5);
    ySel = 1; #2; check("R2", 8'hA5);
    dataBus = 8'h3C; yLoad = 0;
    @(negedge clk); #2; check("R3", 8'hA5);
    ySel = 0;
  endtask

  task automatic testSharedSweep();
    logic [7:0] xs [5] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    for (int k = 0; k < 5; k++) begin
      for (int m = 0; m < 8; m++) begin
        @(negedge clk); clearSel();
        xVal = xs[k]; xShareEn = m[2]; pcHiLoad = m[1]; arHiLoad = m[0];
        #2;
        if (!m[2])             check("R8", sharedModel(m[2], m[1], m[0], xs[k]));
        else if (m[1] || m[0]) check("R5", sharedModel(m[2], m[1], m[0], xs[k]));
        else                   check("R4", sharedModel(m[2], m[1], m[0], xs[k]));
      end
    end
  endtask

  task automatic testOtherSources();
    loadY(8'h96);
    accVal = 8'h12; tmpVal = 8'hE7; xVal = 8'hFF;
    @(negedge clk); clearSel(); accSel = 1; #2; check("R6", 8'h12);
    @(negedge clk); clearSel(); tmpSel = 1; #2; check("R6", 8'hE7);
    @(negedge clk); clearSel(); ySel = 1; pcHiLoad = 1; arHiLoad = 1; #2; check("R8", 8'h96);
    @(negedge clk); clearSel(); pcHiLoad = 1; #2; check("R7", 8'h00);
    @(negedge clk); clearSel(); #2; check("R7", 8'h00);
  endtask

  task automatic testSameCycle();
    loadY(8'h11);
    @(negedge clk); clearSel(); ySel = 1; yLoad = 1; dataBus = 8'hC3; #2;
    check("R9", 8'h11);
    @(negedge clk); yLoad = 0; #2;
    check("R9", 8'hC3);
    clearSel();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        testReset();
        testYLoadHold();
        testSharedSweep();
        testOtherSources();
        testSameCycle();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule